// File: doc/BRIEF.md
# External Interrupt Sense Logic

This block watches one pin of an 8-bit input port and turns activity on it into an interrupt request for the processor's control logic. The pin first passes through a synchroniser. A two-bit sense field then picks the kind of event that counts: a low level, a falling edge or a rising edge. A fourth code is reserved and never fires. A detected event shows up in a flag bit. The flag, an enable bit and the global interrupt enable together raise a request. A disable line from the pipeline can hold that request off, for example while an instruction must not be interrupted.

A timer-overflow request from elsewhere in the chip enters the same output stage. When both sources are active, the external pin wins. Each source puts its own fixed 22-bit vector on the vector output while the request is high. Software reaches the sense field, the enable bit and the flag through a small write port with a 2-bit register select. The flag byte is presented on an output so that it can be read.

Top module: `ext_irq_sense`

## Requirements
- R1: After a synchronous reset the flag byte, the request and the vector are all zero. The sense field resets to level-low (00) and the enable bit resets to 0.
- R2: The port pin at index IRQ_PIN passes through SYNC_STAGES flip-flops, with a reset value of 1. An input change sampled at clock edge k can change the flag at edge k+SYNC_STAGES at the earliest, and the request one edge after that.
- R3: With sense 00 (level-low), flag bit 6 follows the inverse of the synchronised pin on every cycle. It is not latched, so it falls as soon as the pin is seen high, and a clear write has no lasting effect.
- R4: With sense 10 (falling edge), a synchronised high-to-low transition sets flag bit 6. The flag then holds until it is cleared.
- R5: With sense 11 (rising edge), a synchronised low-to-high transition sets flag bit 6. The flag then holds until it is cleared.
- R6: With sense 01 (reserved), the flag is never set. A flag that was already set keeps its value until it is cleared.
- R7: A write with select 2 and data bit 6 = 1 clears the flag in edge and reserved modes. A write with data bit 6 = 0 leaves the flag unchanged. If an edge is detected in the same cycle as the clear, the flag ends up set.
- R8: Register writes use select 0 for the sense field (data bits 1:0) and select 1 for the enable bit (data bit 6). Select 3 writes nothing. Each write takes effect at the next clock edge.
- R9: The registered request is high one cycle after the following condition holds: global enable is 1, pipeline disable is 0, and either (flag AND enable) or the timer-overflow request is 1.
- R10: While a request is high, the vector is EXT_VEC if flag AND enable was 1, and TMR_VEC otherwise. While no request is raised, the vector is zero.
- R11: Port pins other than IRQ_PIN have no effect on the flag, the request or the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_pins_i | input | PORT_W | Port input pins; only IRQ_PIN is watched |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 sense, 1 enable, 2 flag clear, 3 none |
| cfg_wdata_i | input | REG_W | Write data |
| gie_i | input | 1 | Global interrupt enable |
| pipe_dis_i | input | 1 | Pipeline request for interrupts to be held off |
| tmr_ovf_req_i | input | 1 | Timer overflow request, already flagged and masked |
| flag_reg_o | output | REG_W | Flag byte; the flag sits in bit FLAG_BIT |
| irq_req_o | output | 1 | Registered interrupt request |
| irq_vec_o | output | VEC_W | Vector of the source being requested |

## Verification
The bench builds the block with its defaults: eight pins, pin 0 watched, a two-stage synchroniser and a 22-bit vector. The short synchroniser keeps the bench's pin history only three entries deep, so every cycle's flag, request and vector can be predicted from the last few pin values and the register state. All four sense codes are swept in turn, and the flag carries over between them, so the reserved mode starts from a set flag. Gate inputs, enable writes, clear writes with bit 6 high and low, and traffic on the other pins are all derived from the cycle count. This brings every combination of sources and gates within reach of a few hundred cycles.

// File: rtl/eis_pkg.sv
package eis_pkg;

  // Sense codes; the numeric values are decoded by software, keep them fixed.
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_RSV  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  // Register select on the write port.
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_MASK = 2'd1,
    SEL_FLAG = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  generate
    if (STAGES <= 1) begin : g_single
      logic q_r;
      always_ff @(posedge clk) begin
        if (rst) q_r <= RST_VAL;
        else     q_r <= d_i;
      end
      assign q_o = q_r;
    end else begin : g_chain
      logic [STAGES-1:0] chain_r;
      always_ff @(posedge clk) begin
        if (rst) chain_r <= {STAGES{RST_VAL}};
        else     chain_r <= {chain_r[STAGES-2:0], d_i};
      end
      assign q_o = chain_r[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/eis_regs.sv
module eis_regs
  import eis_pkg::*;
#(
  parameter int REG_W      = 8,
  parameter int ENABLE_BIT = 6,
  parameter int FLAG_BIT   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output sense_e           sense_o,
  output logic             enable_o,
  output logic             clr_o
);

  sense_e sense_r;
  logic   enable_r;
  logic   unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_r  <= SENSE_LOW;
      enable_r <= 1'b0;
    end else if (we_i) begin
      if (sel_i == SEL_CTRL) sense_r  <= sense_e'(wdata_i[1:0]);
      if (sel_i == SEL_MASK) enable_r <= wdata_i[ENABLE_BIT];
    end
  end

  // Write-one-to-clear strobe for the flag.
  assign clr_o    = we_i && (sel_i == SEL_FLAG) && wdata_i[FLAG_BIT];
  assign sense_o  = sense_r;
  assign enable_o = enable_r;

  AST_NONE_SEL_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (we_i && sel_i == SEL_NONE) |=> ($stable(sense_r) && $stable(enable_r))) else $error("select 3 changed a register"); // R8

endmodule

// File: rtl/eis_detect.sv
module eis_detect
  import eis_pkg::*;
#(
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   pin_s_i,
  input  sense_e sense_i,
  input  logic   clr_i,
  output logic   flag_o
);

  logic prev_r;
  logic flag_r;
  logic fall_w;
  logic rise_w;
  logic flag_nx;

  assign fall_w =  prev_r && !pin_s_i;
  assign rise_w = !prev_r &&  pin_s_i;

  always_comb begin
    unique case (sense_i)
      SENSE_LOW:  flag_nx = !pin_s_i;
      SENSE_FALL: flag_nx = (flag_r && !clr_i) || fall_w;
      SENSE_RISE: flag_nx = (flag_r && !clr_i) || rise_w;
      default:    flag_nx =  flag_r && !clr_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_r <= IDLE_LEVEL;
      flag_r <= 1'b0;
    end else begin
      prev_r <= pin_s_i;
      flag_r <= flag_nx;
    end
  end

  assign flag_o = flag_r;

  AST_LEVEL_DROP: assert property (@(posedge clk) disable iff (rst)
    (sense_i == SENSE_LOW && pin_s_i) |=> !flag_r) else $error("level flag held"); // R3
  AST_FALL_SETS: assert property (@(posedge clk) disable iff (rst)
    (sense_i == SENSE_FALL && prev_r && !pin_s_i) |=> flag_r) else $error("falling edge missed"); // R4
  AST_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
    (sense_i == SENSE_RISE && !prev_r && pin_s_i) |=> flag_r) else $error("rising edge missed"); // R5
  AST_RSV_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (sense_i == SENSE_RSV && !flag_r) |=> !flag_r) else $error("reserved mode fired"); // R6
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (sense_i == SENSE_RSV && clr_i) |=> !flag_r) else $error("clear ignored"); // R7

endmodule

// File: rtl/eis_arbiter.sv
module eis_arbiter #(
  parameter int              VEC_W   = 22,
  parameter logic [VEC_W-1:0] EXT_VEC = 22'h000002,
  parameter logic [VEC_W-1:0] TMR_VEC = 22'h000012
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flag_i,
  input  logic             enable_i,
  input  logic             tmr_i,
  input  logic             gie_i,
  input  logic             dis_i,
  output logic             req_o,
  output logic [VEC_W-1:0] vec_o
);

  logic             ext_pend_w;
  logic             open_w;
  logic             req_nx;
  logic [VEC_W-1:0] vec_nx;
  logic             req_r;
  logic [VEC_W-1:0] vec_r;

  assign ext_pend_w = flag_i && enable_i;
  assign open_w     = gie_i && !dis_i;

  // Fixed order: the external pin is served before the timer.
  always_comb begin
    req_nx = open_w && (ext_pend_w || tmr_i);
    vec_nx = '0;
    if (req_nx) vec_nx = ext_pend_w ? EXT_VEC : TMR_VEC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_r <= 1'b0;
      vec_r <= '0;
    end else begin
      req_r <= req_nx;
      vec_r <= vec_nx;
    end
  end

  assign req_o = req_r;
  assign vec_o = vec_r;

  AST_GATED_OFF: assert property (@(posedge clk) disable iff (rst)
    (!gie_i || dis_i) |=> !req_r) else $error("request leaked past gate"); // R9
  AST_EXT_FIRST: assert property (@(posedge clk) disable iff (rst)
    (open_w && flag_i && enable_i) |=> (req_r && vec_r == EXT_VEC)) else $error("external not first"); // R10
  AST_IDLE_VEC: assert property (@(posedge clk) disable iff (rst)
    !req_r |-> (vec_r == '0)) else $error("vector without request"); // R10

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eis_pkg::*;
#(
  parameter int               PORT_W      = 8,
  parameter int               IRQ_PIN     = 0,
  parameter int               SYNC_STAGES = 2,
  parameter int               REG_W       = 8,
  parameter int               ENABLE_BIT  = 6,
  parameter int               FLAG_BIT    = 6,
  parameter int               VEC_W       = 22,
  parameter logic [VEC_W-1:0] EXT_VEC     = 22'h000002,
  parameter logic [VEC_W-1:0] TMR_VEC     = 22'h000012
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] port_pins_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [REG_W-1:0]  cfg_wdata_i,
  input  logic              gie_i,
  input  logic              pipe_dis_i,
  input  logic              tmr_ovf_req_i,
  output logic [REG_W-1:0]  flag_reg_o,
  output logic              irq_req_o,
  output logic [VEC_W-1:0]  irq_vec_o
);

  localparam logic IDLE_LEVEL = 1'b1;

  logic   pin_raw;
  logic   pin_s;
  logic   unused_pins;
  sense_e sense;
  logic   enable;
  logic   clr;
  logic   flag;

  assign pin_raw     = port_pins_i[IRQ_PIN];
  assign unused_pins = ^port_pins_i;

  eis_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_LEVEL)) u_sync (
    .clk (clk), .rst (rst), .d_i (pin_raw), .q_o (pin_s)
  );

  eis_regs #(.REG_W(REG_W), .ENABLE_BIT(ENABLE_BIT), .FLAG_BIT(FLAG_BIT)) u_regs (
    .clk (clk), .rst (rst), .we_i (cfg_we_i), .sel_i (cfg_sel_i),
    .wdata_i (cfg_wdata_i), .sense_o (sense), .enable_o (enable), .clr_o (clr)
  );

  eis_detect #(.IDLE_LEVEL(IDLE_LEVEL)) u_detect (
    .clk (clk), .rst (rst), .pin_s_i (pin_s), .sense_i (sense),
    .clr_i (clr), .flag_o (flag)
  );

  eis_arbiter #(.VEC_W(VEC_W), .EXT_VEC(EXT_VEC), .TMR_VEC(TMR_VEC)) u_arb (
    .clk (clk), .rst (rst), .flag_i (flag), .enable_i (enable),
    .tmr_i (tmr_ovf_req_i), .gie_i (gie_i), .dis_i (pipe_dis_i),
    .req_o (irq_req_o), .vec_o (irq_vec_o)
  );

  always_comb begin
    flag_reg_o           = '0;
    flag_reg_o[FLAG_BIT] = flag;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!irq_req_o && flag_reg_o == '0)) else $error("outputs not cleared by reset"); // R1

endmodule

// File: tb/ext_irq_sense_bench.sv
module ext_irq_sense_bench;

  localparam int          S   = 2;
  localparam logic [21:0] EXT = 22'h000002;
  localparam logic [21:0] TMR = 22'h000012;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pins = 8'hFF;
  logic        we = 1'b0;
  logic [1:0]  sel = 2'd3;
  logic [7:0]  wd = 8'h00;
  logic        gie = 1'b0;
  logic        dis = 1'b0;
  logic        tmr = 1'b0;
  logic [7:0]  flag_reg;
  logic        req;
  logic [21:0] vec;

  int errs = 0;
  int checks = 0;

  // Bench-side prediction state
  logic       m_flag = 1'b0;
  logic       m_mask = 1'b0;
  logic [1:0] m_mode = 2'b00;
  logic       m_req = 1'b0;
  logic [21:0] m_vec = '0;
  logic       hist [0:S];

  always #10 clk = ~clk;

  ext_irq_sense u_ext_irq_sense (
    .clk (clk), .rst (rst), .port_pins_i (pins), .cfg_we_i (we),
    .cfg_sel_i (sel), .cfg_wdata_i (wd), .gie_i (gie), .pipe_dis_i (dis),
    .tmr_ovf_req_i (tmr), .flag_reg_o (flag_reg), .irq_req_o (req),
    .irq_vec_o (vec)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] p, input logic w, input logic [1:0] s,
                      input logic [7:0] d, input logic g, input logic ds, input logic t);
    logic a, b, clr, nf, pend, nreq;
    string ftag;
    pins = p; we = w; sel = s; wd = d; gie = g; dis = ds; tmr = t;
    @(posedge clk);
    a = hist[S-1];
    b = hist[S];
    clr = w && (s == 2'd2) && d[6];
    case (m_mode)
      2'b00: begin nf = !a; ftag = "R3"; end
      2'b10: begin nf = (m_flag && !clr) || (b && !a); ftag = clr ? "R7" : "R4"; end
      2'b11: begin nf = (m_flag && !clr) || (!b && a); ftag = clr ? "R7" : "R5"; end
      default: begin nf = m_flag && !clr; ftag = clr ? "R7" : "R6"; end
    endcase
    pend = m_flag && m_mask;
    nreq = g && !ds && (pend || t);
    m_req = nreq;
    m_vec = !nreq ? 22'd0 : (pend ? EXT : TMR);
    m_flag = nf;
    if (w && s == 2'd0) m_mode = d[1:0];
    if (w && s == 2'd1) m_mask = d[6];
    for (int i = S; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = p[0];
    @(negedge clk);
    check(ftag, {24'd0, flag_reg}, {24'd0, 1'b0, m_flag, 6'd0});
    check("R9 request", {31'd0, req}, {31'd0, m_req});
    check("R10 vector", {10'd0, vec}, {10'd0, m_vec});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [1:0] order [0:3];
    order[0] = 2'b10; order[1] = 2'b11; order[2] = 2'b01; order[3] = 2'b00;
    for (int i = 0; i <= S; i++) hist[i] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset values
    check("R1 flag", {24'd0, flag_reg}, 32'd0);
    check("R1 req", {31'd0, req}, 32'd0);
    check("R1 vec", {10'd0, vec}, 32'd0);
    // R1: sense defaults to level-low, enable defaults to 0
    for (int c = 0; c < 5; c++) step(8'hFE, 1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 1'b0);
    check("R1 default level sense", {31'd0, flag_reg[6]}, 32'd1);
    check("R1 default enable off", {31'd0, req}, 32'd0);
    for (int c = 0; c < 4; c++) step(8'hFF, 1'b0, 2'd3, 8'h00, 1'b0, 1'b0, 1'b0);

    // R2: latency in falling-edge mode
    step(8'hFF, 1'b1, 2'd0, 8'h02, 1'b1, 1'b0, 1'b0);
    step(8'hFF, 1'b1, 2'd1, 8'h40, 1'b1, 1'b0, 1'b0);
    step(8'hFF, 1'b1, 2'd2, 8'h40, 1'b1, 1'b0, 1'b0);
    step(8'hFE, 1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 1'b0);
    check("R2 edge k", {31'd0, flag_reg[6]}, 32'd0);
    step(8'hFE, 1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 1'b0);
    check("R2 edge k+1", {31'd0, flag_reg[6]}, 32'd0);
    step(8'hFE, 1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 1'b0);
    check("R2 edge k+2 flag", {31'd0, flag_reg[6]}, 32'd1);
    check("R2 edge k+2 req", {31'd0, req}, 32'd0);
    step(8'hFE, 1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 1'b0);
    check("R2 edge k+3 req", {31'd0, req}, 32'd1);
    check("R10 ext vector", {10'd0, vec}, {10'd0, EXT});

    // R11: other pins toggle, watched pin stays high
    step(8'hFF, 1'b1, 2'd2, 8'h40, 1'b0, 1'b0, 1'b0);
    for (int c = 0; c < 8; c++) begin
      step({7'(c * 45 + 3), 1'b1}, 1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 1'b0);
      check("R11 other pins", {31'd0, flag_reg[6]}, 32'd0);
    end

    // Sweep all sense codes; flag carries from one mode into the next.
    for (int m = 0; m < 4; m++) begin
      step(8'hFF, 1'b1, 2'd0, {6'd0, order[m]}, 1'b0, 1'b0, 1'b0);
      for (int c = 0; c < 200; c++) begin
        logic [7:0] cv;
        logic p0, w;
        cv = 8'(c);
        p0 = ((((c * 5) >> 2) ^ (c >> 4)) & 1) != 0;
        w  = (c % 9) == 4;
        step({7'(c * 37 + m), p0}, w, 2'(1 + (c / 9) % 3), 8'(c * 29 + m * 7),
             cv[3] | cv[5], cv[4] & cv[2], cv[6] & cv[1]);
      end
    end

    // R8: select 3 writes nothing
    step(8'hFF, 1'b1, 2'd0, 8'h02, 1'b0, 1'b0, 1'b0);
    step(8'hFF, 1'b1, 2'd3, 8'hFF, 1'b0, 1'b0, 1'b0);
    step(8'hFE, 1'b0, 2'd3, 8'h00, 1'b0, 1'b0, 1'b0);
    step(8'hFE, 1'b0, 2'd3, 8'h00, 1'b0, 1'b0, 1'b0);
    step(8'hFE, 1'b0, 2'd3, 8'h00, 1'b0, 1'b0, 1'b0);
    check("R8 select 3 kept falling mode", {31'd0, flag_reg[6]}, 32'd1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule